// File: doc/BRIEF.md
# Non-Volatile Array Erase/Program Self-Test Sequencer

This block runs a fixed self-test on a word-organised non-volatile array. It never touches the array directly. Instead it issues one command at a time to the array's operation controller over a simple valid/acknowledge command port, and it judges the read data that comes back. After a start pulse, the sequence has these steps:

1. Load the array and charge-pump trim words.
2. Program every word to zero, so that no old content survives the erase.
3. Turn the high-voltage switch on with a test-register write, erase the whole array, and turn the switch off again.
4. Read back every word and expect all ones.
5. Program a pseudo-random pattern into every word and read it back for comparison.

The block can be used as a production or power-on self-test. At the end it gives a one-cycle done pulse with a pass verdict. It also keeps the address and the step of the first miscompare. The default size is 512 words of 16 bits, which is 8K bits.

Top module: `nvm_selftest_seq`

## Requirements
- R1: After reset, busy, done, pass, fail_flag and cmd_valid are 0. No command is issued until start is seen while idle.
- R2: The first two commands are trim writes (cmd_op 1). Address 0 carries the array trim and address 1 carries the pump trim, each zero-extended in cmd_wdata. Both values are the ones present on the inputs in the cycle start was accepted.
- R3: Next come program commands (cmd_op 3) with data 0, one to every address from 0 up to the last. All of them are issued before any erase.
- R4: A test-register write (cmd_op 2) with data 1 comes before the single erase command (cmd_op 4). The erase is followed at once by a test-register write with data 0. The erase is never issued while the switch is off.
- R5: After the switch-off, read commands (cmd_op 5) go to every address in ascending order. Each response is expected to be all ones.
- R6: Next, program commands write a pattern word to every address in ascending order, and the same words are then expected from reads of every address. The word for address 0 is the seed latched at start, with 0 replaced by 1. Each following word is {s[14:0], s[15]^s[13]^s[12]^s[10]} of the previous one, truncated to the data width.
- R7: A command keeps cmd_op, cmd_addr and cmd_wdata unchanged while cmd_valid is high and cmd_ack is low. It completes in the cycle cmd_ack is high.
- R8: The first miscompare sets fail_flag and latches fail_addr and fail_phase. fail_phase is 6 for the all-ones check and 8 for the pattern check. Later miscompares change none of these. The sequence still issues all 4N+5 commands.
- R9: done is a one-cycle pulse in the cycle after the last read completes. pass is high only during done, and only when no miscompare occurred.
- R10: start is ignored while busy. The fail result stays held after done until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a self-test when idle |
| seed | input | 16 | Pattern generator seed, latched at start |
| trim_array | input | TRIM_W | Array trim value, latched at start |
| trim_pump | input | TRIM_W | Charge-pump trim value, latched at start |
| cmd_valid | output | 1 | Command request |
| cmd_op | output | 3 | Command code: 1 trim, 2 test register, 3 program, 4 erase, 5 read |
| cmd_addr | output | ADDR_W | Word address or trim-register index |
| cmd_wdata | output | DATA_W | Write data |
| cmd_ack | input | 1 | Command completion from the operation controller |
| rsp_data | input | DATA_W | Read data, valid with cmd_ack on reads |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pass | output | 1 | Verdict, valid with done |
| fail_flag | output | 1 | A miscompare has occurred |
| fail_addr | output | ADDR_W | Address of the first miscompare |
| fail_phase | output | 4 | Step code of the first miscompare |

## Verification
The sharpest coincidence is a miscompare on the last read of the all-ones check. That read lands in the same cycle as the pattern generator reload and the hand-off to the pattern-program step. It is provoked by a stuck-at-zero bit at the top address in the bench's array model, and the run must report step code 6 with the top address, not step code 8. A second coincidence, a start pulse arriving while a run is busy, is provoked mid-sequence; the test then checks that the command stream keeps its exact 4N+5 length and order. Every command is compared against an arithmetically generated stream, and each fault pattern has its first-failure location computed ahead of the run.

// File: rtl/nvm_selftest_pkg.sv
package nvm_selftest_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [3:0] {
        PH_IDLE        = 4'd0,
        PH_TRIM        = 4'd1,
        PH_SANITIZE    = 4'd2,
        PH_HV_ON       = 4'd3,
        PH_ERASE       = 4'd4,
        PH_HV_OFF      = 4'd5,
        PH_ERASE_CHK   = 4'd6,
        PH_PATTERN     = 4'd7,
        PH_PATTERN_CHK = 4'd8,
        PH_DONE        = 4'd9
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_TRIM    = 3'd1,
        OP_TESTREG = 3'd2,
        OP_PROG    = 3'd3,
        OP_ERASE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
        return (s == '0) ? LFSR_W'(1) : s;
    endfunction

endpackage

// File: rtl/nvm_selftest_addr.sv
module nvm_selftest_addr #(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    // Wraps to zero after the top word, so each sweep starts clean.
    always_ff @(posedge clk) begin
        if (rst || clear)
            addr <= '0;
        else if (step)
            addr <= addr + ADDR_W'(1);
    end

    assign last = (addr == {ADDR_W{1'b1}});
endmodule

// File: rtl/nvm_selftest_pattern.sv
module nvm_selftest_pattern
    import nvm_selftest_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    input  logic              step,
    output logic [LFSR_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= LFSR_W'(1);
        else if (load)
            word <= seed_fix(seed);
        else if (step)
            word <= lfsr_step(word);
    end
endmodule

// File: rtl/nvm_selftest_cmp.sv
module nvm_selftest_cmp #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              check,
    input  logic [DATA_W-1:0] got,
    input  logic [DATA_W-1:0] expect_w,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        phase,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [3:0]        fail_phase
);
    logic mismatch;
    assign mismatch = check && (got != expect_w);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            fail       <= 1'b0;
            fail_addr  <= '0;
            fail_phase <= '0;
        end else if (mismatch && !fail) begin
            fail       <= 1'b1;
            fail_addr  <= addr;
            fail_phase <= phase;
        end
    end
endmodule

// File: rtl/nvm_selftest_seq.sv
module nvm_selftest_seq
    import nvm_selftest_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16,   // must not exceed LFSR_W
    parameter int TRIM_W = 8     // must not exceed DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [15:0]       seed,
    input  logic [TRIM_W-1:0] trim_array,
    input  logic [TRIM_W-1:0] trim_pump,
    output logic              cmd_valid,
    output logic [2:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_ack,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail_flag,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [3:0]        fail_phase
);
    phase_e              st, st_nx;
    logic                trim_sel;
    logic [LFSR_W-1:0]   seed_q;
    logic [TRIM_W-1:0]   trim_a_q, trim_p_q;
    logic [DATA_W-1:0]   trim_word;
    logic                accept, fire, last;
    logic [ADDR_W-1:0]   addr;
    logic [LFSR_W-1:0]   pat_word;
    op_e                 op;

    assign accept = (st == PH_IDLE) && start;
    assign fire   = cmd_valid && cmd_ack;

    // ---------------- phase sequencing ----------------
    always_comb begin
        st_nx = st;
        unique case (st)
            PH_IDLE:        if (start)              st_nx = PH_TRIM;
            PH_TRIM:        if (fire && trim_sel)   st_nx = PH_SANITIZE;
            PH_SANITIZE:    if (fire && last)       st_nx = PH_HV_ON;
            PH_HV_ON:       if (fire)               st_nx = PH_ERASE;
            PH_ERASE:       if (fire)               st_nx = PH_HV_OFF;
            PH_HV_OFF:      if (fire)               st_nx = PH_ERASE_CHK;
            PH_ERASE_CHK:   if (fire && last)       st_nx = PH_PATTERN;
            PH_PATTERN:     if (fire && last)       st_nx = PH_PATTERN_CHK;
            PH_PATTERN_CHK: if (fire && last)       st_nx = PH_DONE;
            PH_DONE:                                st_nx = PH_IDLE;
            default:                                st_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PH_IDLE;
            trim_sel <= 1'b0;
            seed_q   <= '0;
            trim_a_q <= '0;
            trim_p_q <= '0;
        end else begin
            st <= st_nx;
            if (accept) begin
                trim_sel <= 1'b0;
                seed_q   <= seed;
                trim_a_q <= trim_array;
                trim_p_q <= trim_pump;
            end else if (fire && st == PH_TRIM) begin
                trim_sel <= 1'b1;
            end
        end
    end

    // ---------------- shared address sweep ----------------
    logic sweep_step;
    assign sweep_step = fire && (st == PH_SANITIZE || st == PH_ERASE_CHK ||
                                 st == PH_PATTERN  || st == PH_PATTERN_CHK);

    nvm_selftest_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .clear(accept),
        .step (sweep_step),
        .addr (addr),
        .last (last)
    );

    // ---------------- pattern generator (replayed for check) ----------------
    logic pat_load, pat_step;
    assign pat_load = fire && last && (st == PH_ERASE_CHK || st == PH_PATTERN);
    assign pat_step = fire && (st == PH_PATTERN || st == PH_PATTERN_CHK);

    nvm_selftest_pattern u_pat (
        .clk (clk),
        .rst (rst),
        .load(pat_load),
        .seed(seed_q),
        .step(pat_step),
        .word(pat_word)
    );

    // ---------------- trim word formatting ----------------
    generate
        if (TRIM_W < DATA_W) begin : g_trim_pad
            assign trim_word = {{(DATA_W-TRIM_W){1'b0}}, (trim_sel ? trim_p_q : trim_a_q)};
        end else begin : g_trim_full
            assign trim_word = trim_sel ? trim_p_q : trim_a_q;
        end
    endgenerate

    // ---------------- command formation ----------------
    always_comb begin
        op        = OP_NONE;
        cmd_addr  = '0;
        cmd_wdata = '0;
        unique case (st)
            PH_TRIM: begin
                op        = OP_TRIM;
                cmd_addr  = ADDR_W'(trim_sel);
                cmd_wdata = trim_word;
            end
            PH_SANITIZE: begin
                op       = OP_PROG;
                cmd_addr = addr;
            end
            PH_HV_ON: begin
                op        = OP_TESTREG;
                cmd_wdata = DATA_W'(1);
            end
            PH_ERASE:     op = OP_ERASE;
            PH_HV_OFF:    op = OP_TESTREG;
            PH_ERASE_CHK, PH_PATTERN_CHK: begin
                op       = OP_READ;
                cmd_addr = addr;
            end
            PH_PATTERN: begin
                op        = OP_PROG;
                cmd_addr  = addr;
                cmd_wdata = pat_word[DATA_W-1:0];
            end
            default: ;
        endcase
    end

    assign cmd_op    = op;
    assign cmd_valid = (op != OP_NONE);

    // ---------------- read-back judgement ----------------
    logic              chk_en;
    logic [DATA_W-1:0] chk_exp;
    assign chk_en  = fire && (st == PH_ERASE_CHK || st == PH_PATTERN_CHK);
    assign chk_exp = (st == PH_ERASE_CHK) ? {DATA_W{1'b1}} : pat_word[DATA_W-1:0];

    nvm_selftest_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .check     (chk_en),
        .got       (rsp_data),
        .expect_w  (chk_exp),
        .addr      (addr),
        .phase     (st),
        .fail      (fail_flag),
        .fail_addr (fail_addr),
        .fail_phase(fail_phase)
    );

    assign busy = (st != PH_IDLE);
    assign done = (st == PH_DONE);
    assign pass = done && !fail_flag;
endmodule

// File: rtl/nvm_selftest_seq_sva.sv
module nvm_selftest_seq_sva #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              pass,
    input logic              fail_flag,
    input logic              cmd_valid,
    input logic              cmd_ack,
    input logic [2:0]        cmd_op,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [DATA_W-1:0] cmd_wdata
);
    // High-voltage switch state as seen from completed test-register writes.
    logic hv_q;
    always_ff @(posedge clk) begin
        if (rst)
            hv_q <= 1'b0;
        else if (cmd_valid && cmd_ack && cmd_op == 3'd2)
            hv_q <= cmd_wdata[0];
    end

    assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_op) &&
                                  $stable(cmd_addr) && $stable(cmd_wdata));

    assert_erase_hv_on_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == 3'd4 |-> hv_q);

    assert_hv_off_at_end_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !hv_q);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_pass_qualified_R9: assert property (@(posedge clk) disable iff (rst)
        pass |-> done && !fail_flag);

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        fail_flag && !(start && !busy) |=> fail_flag);

    assert_cmd_only_busy_R10: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> busy);
endmodule

bind nvm_selftest_seq nvm_selftest_seq_sva #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .pass     (pass),
    .fail_flag(fail_flag),
    .cmd_valid(cmd_valid),
    .cmd_ack  (cmd_ack),
    .cmd_op   (cmd_op),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata)
);

// File: tb/nvm_selftest_seq_test.sv
module nvm_selftest_seq_test;
    localparam int AW = 5;
    localparam int NW = 1 << AW;
    localparam int DW = 16;
    localparam int TW = 8;
    localparam int TOTAL = 4 * NW + 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [15:0]   seed = '0;
    logic [TW-1:0] trim_array = '0, trim_pump = '0;
    logic          cmd_valid;
    logic [2:0]    cmd_op;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_wdata;
    logic          cmd_ack = 1'b0;
    logic [DW-1:0] rsp_data = '0;
    logic          busy, done, pass, fail_flag;
    logic [AW-1:0] fail_addr;
    logic [3:0]    fail_phase;

    nvm_selftest_seq #(.ADDR_W(AW), .DATA_W(DW), .TRIM_W(TW)) uut (
        .clk(clk), .rst(rst), .start(start), .seed(seed),
        .trim_array(trim_array), .trim_pump(trim_pump),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .rsp_data(rsp_data),
        .busy(busy), .done(done), .pass(pass), .fail_flag(fail_flag),
        .fail_addr(fail_addr), .fail_phase(fail_phase)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0, n_fails = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- array / operation-controller model ----------------
    logic [15:0] mem       [NW];
    logic [15:0] stuck     [NW];   // bits forced to 0 in storage
    logic [15:0] flip      [NW];   // bits inverted on programming
    bit          sanitized [NW];
    bit          hv = 0;
    int          lat = 0, wcnt = 0, stepn = 0, last_ack_cyc = 0;
    int          err [7];          // trim, sanitize, hv, erase-check, pattern, pattern-check, extra
    logic [15:0] seed_e;
    logic [7:0]  ta_e, tp_e;

    function automatic logic [15:0] pat(input int a);
        logic [15:0] s = (seed_e == 16'h0) ? 16'h0001 : seed_e;
        for (int i = 0; i < a; i++) s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
        return s;
    endfunction

    task automatic expect_cmd(input int k, output int cat, output int op,
                              output int a, output logic [15:0] d, output bit wr);
        d = 16'h0; a = 0; wr = 1;
        if (k < 2)               begin cat = 0; op = 1; a = k; d = {8'h0, (k == 1) ? tp_e : ta_e}; end
        else if (k < NW + 2)     begin cat = 1; op = 3; a = k - 2; end
        else if (k == NW + 2)    begin cat = 2; op = 2; d = 16'h1; end
        else if (k == NW + 3)    begin cat = 2; op = 4; end
        else if (k == NW + 4)    begin cat = 2; op = 2; end
        else if (k < 2 * NW + 5) begin cat = 3; op = 5; a = k - (NW + 5); wr = 0; end
        else if (k < 3 * NW + 5) begin cat = 4; op = 3; a = k - (2 * NW + 5); d = pat(a); end
        else if (k < TOTAL)      begin cat = 5; op = 5; a = k - (3 * NW + 5); wr = 0; end
        else                     begin cat = 6; op = 0; end
    endtask

    task automatic serve();
        int cat, op, a; logic [15:0] d; bit wr;
        expect_cmd(stepn, cat, op, a, d, wr);
        if (int'(cmd_op) != op || int'(cmd_addr) != a || (wr && cmd_wdata != d))
            err[cat]++;
        case (cmd_op)
            3'd2: hv = cmd_wdata[0];
            3'd3: begin
                mem[cmd_addr] = (cmd_wdata & ~stuck[cmd_addr]) ^ flip[cmd_addr];
                if (cmd_wdata == 16'h0) sanitized[cmd_addr] = 1;
            end
            3'd4: begin
                if (!hv) err[2]++;
                for (int i = 0; i < NW; i++) begin
                    if (!sanitized[i]) err[1]++;
                    mem[i] = ~stuck[i];
                end
            end
            3'd5: rsp_data = mem[cmd_addr];
            default: ;
        endcase
        stepn++;
        last_ack_cyc = cyc;
    endtask

    initial begin
        for (int i = 0; i < NW; i++) begin
            mem[i] = 16'(i * 16'h1357); stuck[i] = '0; flip[i] = '0; sanitized[i] = 0;
        end
        forever begin
            @(negedge clk);
            if (cmd_ack) begin
                cmd_ack = 0; wcnt = 0;
            end else if (!rst && cmd_valid) begin
                if (wcnt >= lat) begin cmd_ack = 1; serve(); end
                else wcnt++;
            end
        end
    end

    // ---------------- one full self-test run ----------------
    task automatic run(input logic [15:0] sd, input logic [7:0] ta, input logic [7:0] tp,
                       input int l, input bit mid_start, input string tag);
        bit exp_fail = 0; int exp_addr = 0; int exp_ph = 0; int d_cyc;
        seed_e = sd; ta_e = ta; tp_e = tp; lat = l; stepn = 0;
        for (int i = 0; i < 7; i++) err[i] = 0;
        for (int i = 0; i < NW; i++) sanitized[i] = 0;
        // first failure computed from the fault configuration
        for (int a = 0; a < NW && !exp_fail; a++)
            if (stuck[a] != 16'h0) begin exp_fail = 1; exp_addr = a; exp_ph = 6; end
        for (int a = 0; a < NW && !exp_fail; a++)
            if (((pat(a) & ~stuck[a]) ^ flip[a]) != pat(a)) begin exp_fail = 1; exp_addr = a; exp_ph = 8; end

        @(negedge clk); seed = sd; trim_array = ta; trim_pump = tp; start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1, "R10", {tag, " busy after start"}, busy, 1);
        chk(fail_flag == 0, "R10", {tag, " fail cleared by start"}, fail_flag, 0);
        repeat (3) @(negedge clk);
        seed = ~sd; trim_array = ~ta; trim_pump = ~tp;   // latched copies must be used
        if (mid_start) begin
            repeat (20) @(negedge clk); start = 1;
            @(negedge clk); start = 0;
        end
        while (!done) @(negedge clk);
        d_cyc = cyc;
        chk(err[0] == 0, "R2", {tag, " trim commands"}, err[0], 0);
        chk(err[1] == 0, "R3", {tag, " sanitize sweep"}, err[1], 0);
        chk(err[2] == 0, "R4", {tag, " high-voltage bracket"}, err[2], 0);
        chk(err[3] == 0, "R5", {tag, " all-ones read sweep"}, err[3], 0);
        chk(err[4] == 0 && err[5] == 0, "R6", {tag, " pattern program/read"}, err[4] + err[5], 0);
        chk(err[6] == 0 && stepn == TOTAL, "R8", {tag, " full command count"}, stepn, TOTAL);
        chk(d_cyc == last_ack_cyc + 1, "R9", {tag, " done timing"}, d_cyc, last_ack_cyc + 1);
        chk(pass == !exp_fail, "R9", {tag, " pass verdict"}, pass, !exp_fail);
        chk(fail_flag == exp_fail, "R8", {tag, " fail flag"}, fail_flag, exp_fail);
        if (exp_fail) begin
            chk(int'(fail_addr) == exp_addr, "R8", {tag, " first fail address"}, fail_addr, exp_addr);
            chk(int'(fail_phase) == exp_ph, "R8", {tag, " first fail step"}, fail_phase, exp_ph);
        end
        @(negedge clk);
        chk(done == 0 && pass == 0 && busy == 0, "R9", {tag, " done one cycle"},
            {done, pass, busy}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++; n_checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk({busy, done, pass, fail_flag, cmd_valid} == 5'b0, "R1", "reset outputs",
            {busy, done, pass, fail_flag, cmd_valid}, 0);
        repeat (3) @(negedge clk);
        chk(cmd_valid == 0, "R1", "idle without start", cmd_valid, 0);

        // clean run, zero latency
        run(16'hBEEF, 8'h5A, 8'hC3, 0, 0, "clean-A");
        // zero seed becomes 1, slower controller
        run(16'h0000, 8'h81, 8'h7E, 2, 0, "seed0");
        // stuck bit at the top word: failure on the last all-ones read
        stuck[NW-1] = 16'h0010;
        run(16'h1234, 8'h11, 8'h22, 1, 0, "stuck-top");
        stuck[NW-1] = 16'h0;
        // two pattern faults plus a start pulse while busy
        flip[7] = 16'h8000; flip[20] = 16'h0001;
        run(16'hACE1, 8'h33, 8'h44, 3, 1, "flip-mid");
        flip[7] = 16'h0; flip[20] = 16'h0;
        // two stuck words: first one kept
        stuck[3] = 16'h0100; stuck[12] = 16'hFFFF;
        run(16'h0F0F, 8'hA5, 8'h5A, 1, 0, "stuck-two");
        stuck[3] = 16'h0; stuck[12] = 16'h0;
        repeat (6) @(negedge clk);
        chk(fail_flag == 1 && fail_addr == AW'(3), "R10", "fail held after done",
            {fail_flag, fail_addr}, {1'b1, AW'(3)});
        // next start clears the result, clean again
        run(16'h8001, 8'hFF, 8'h00, 1, 0, "clean-B");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule